// File: doc/BRIEF.md
# Three-Level PWM Input Decoder with Mid-Window Shutdown

This block sits between the comparators of a three-level PWM control input and the gate sequencer of a synchronous buck power stage. It receives two flags, already synchronised to its clock. The first is set while the input is above the upper (rising) threshold. The second is set while the input is below the lower (falling) threshold. From these flags it produces a clean PWM level with hysteresis and a shutdown request.

An input that sits between the two thresholds is a candidate for the third, "off" state. If it stays there without a break for a programmable number of clock cycles, the block raises a shutdown request. The sequencer then holds both gates low. The request drops on the first sample that shows the input above the upper threshold or below the lower one. On that same edge the PWM level takes the side the input moved to, so the sequencer has a valid level from its first cycle out of shutdown.

A sample with both flags set cannot occur on a healthy input. The block treats it as noise: it keeps the decoded state, and the sample breaks any holdoff count that is in progress.

Top module: `pwm_tristate_decoder`

## Requirements
- R1: A sample with the upper flag set and the lower flag clear (code {upper,lower} = 2'b10) drives `pwm_level` to 1 on the next clock edge. A sample with code 2'b01 drives it to 0 on the next edge.
- R2: A sample with both flags clear (code 2'b00, the window) leaves `pwm_level` unchanged, which gives hysteresis between the thresholds.
- R3: `shutdown_req` rises on the edge that samples the HOLD_CYCLES-th consecutive window sample (default 23). It is never set after fewer consecutive window samples.
- R4: While `shutdown_req` is 1, a sample of code 2'b10 or 2'b01 clears it on the next edge. Further window samples keep it at 1.
- R5: Any non-window sample taken before the holdoff completes restarts the count. A later shutdown then needs a fresh run of HOLD_CYCLES window samples.
- R6: A sample with both flags set (code 2'b11) leaves `pwm_level` unchanged and leaves `shutdown_req` unchanged. When no shutdown is active, it restarts the holdoff count.
- R7: On the edge where shutdown clears, `pwm_level` already equals the side the input left toward: 1 for code 2'b10 and 0 for code 2'b01.
- R8: Synchronous reset forces `pwm_level` to 0, clears `shutdown_req` and clears the holdoff count. Window samples taken during reset do not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| above_rise | input | 1 | Input is above the upper (rising) threshold |
| below_fall | input | 1 | Input is below the lower (falling) threshold |
| pwm_level | output | 1 | Decoded PWM level with hysteresis, registered |
| shutdown_req | output | 1 | Request to hold both gates low, registered |

## Verification
The bench runs window stretches of exactly HOLD_CYCLES-1 and HOLD_CYCLES samples. An off-by-one counter would either shut down one edge too early or never reach shutdown. It breaks near-complete window runs with a single edge sample and with a single both-flags sample; a design that only pauses its count on the break would shut down falsely. It also leaves shutdown toward the side opposite the level held before entry, which exposes a design that clears the request but keeps the stale level for one cycle. Random runs of flags and window lengths cover the rest against a model written from the requirements.

// File: rtl/pwm_tristate_pkg.sv
package pwm_tristate_pkg;
  // Encoding is {above_rise, below_fall}
  typedef enum logic [1:0] {
    ZONE_MID  = 2'b00,
    ZONE_LOW  = 2'b01,
    ZONE_HIGH = 2'b10,
    ZONE_BAD  = 2'b11
  } zone_t;
endpackage

// File: rtl/pwm_zone_classify.sv
module pwm_zone_classify
  import pwm_tristate_pkg::*;
(
  input  logic  above_rise,
  input  logic  below_fall,
  output zone_t zone
);
  always_comb begin
    unique case ({above_rise, below_fall})
      2'b10:   zone = ZONE_HIGH;
      2'b01:   zone = ZONE_LOW;
      2'b11:   zone = ZONE_BAD;
      default: zone = ZONE_MID;
    endcase
  end
endmodule

// File: rtl/pwm_level_track.sv
module pwm_level_track
  import pwm_tristate_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  zone_t zone,
  output logic  level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
    end else begin
      case (zone)
        ZONE_HIGH: level <= 1'b1;
        ZONE_LOW:  level <= 1'b0;
        default:   level <= level;
      endcase
    end
  end

  AST_LEVEL_RISE: assert property (@(posedge clk) disable iff (rst)
    zone == ZONE_HIGH |=> level);                                  // R1
  AST_LEVEL_FALL: assert property (@(posedge clk) disable iff (rst)
    zone == ZONE_LOW |=> !level);                                  // R1
  AST_LEVEL_HOLD_MID: assert property (@(posedge clk) disable iff (rst)
    zone == ZONE_MID |=> $stable(level));                          // R2
  AST_LEVEL_HOLD_BAD: assert property (@(posedge clk) disable iff (rst)
    zone == ZONE_BAD |=> $stable(level));                          // R6
endmodule

// File: rtl/pwm_holdoff_timer.sv
module pwm_holdoff_timer
  import pwm_tristate_pkg::*;
#(
  parameter int HOLD_CYCLES = 23
) (
  input  logic  clk,
  input  logic  rst,
  input  zone_t zone,
  output logic  shut
);
  localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      shut <= 1'b0;
    end else begin
      case (zone)
        ZONE_MID: begin
          if (!shut) begin
            if (cnt == LAST) begin
              shut <= 1'b1;
              cnt  <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        ZONE_BAD: begin
          cnt <= '0;
        end
        default: begin
          cnt  <= '0;
          shut <= 1'b0;
        end
      endcase
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);                                                  // R3
  AST_SHUT_NEEDS_MID: assert property (@(posedge clk) disable iff (rst)
    (!shut && zone != ZONE_MID) |=> !shut);                        // R3
  AST_SHUT_CLEAR_EDGE: assert property (@(posedge clk) disable iff (rst)
    (zone == ZONE_HIGH || zone == ZONE_LOW) |=> (!shut && cnt == '0)); // R4
  AST_BAD_RESTART: assert property (@(posedge clk) disable iff (rst)
    zone == ZONE_BAD |=> (cnt == '0 && $stable(shut)));            // R6
  AST_SHUT_STAYS_MID: assert property (@(posedge clk) disable iff (rst)
    (shut && zone == ZONE_MID) |=> shut);                          // R4
endmodule

// File: rtl/pwm_tristate_decoder.sv
module pwm_tristate_decoder
  import pwm_tristate_pkg::*;
#(
  parameter int HOLD_CYCLES = 23
) (
  input  logic clk,
  input  logic rst,
  input  logic above_rise,
  input  logic below_fall,
  output logic pwm_level,
  output logic shutdown_req
);
  zone_t zone;

  pwm_zone_classify u_classify (
    .above_rise (above_rise),
    .below_fall (below_fall),
    .zone       (zone)
  );

  pwm_level_track u_level (
    .clk   (clk),
    .rst   (rst),
    .zone  (zone),
    .level (pwm_level)
  );

  pwm_holdoff_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_holdoff (
    .clk  (clk),
    .rst  (rst),
    .zone (zone),
    .shut (shutdown_req)
  );

  AST_EXIT_SIDE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (shutdown_req && above_rise && !below_fall) |=> (pwm_level && !shutdown_req)); // R7
  AST_EXIT_SIDE_LOW: assert property (@(posedge clk) disable iff (rst)
    (shutdown_req && below_fall && !above_rise) |=> (!pwm_level && !shutdown_req)); // R7
endmodule

// File: tb/pwm_tristate_decoder_test.sv
`timescale 1ns/1ps
module pwm_tristate_decoder_test;
  localparam int HOLD = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic above_rise = 1'b0;
  logic below_fall = 1'b0;
  logic pwm_level, shutdown_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // model state
  bit m_level = 1'b0;
  bit m_shut  = 1'b0;
  int m_run   = 0;

  always #10 clk = ~clk;

  pwm_tristate_decoder #(.HOLD_CYCLES(HOLD)) uut (
    .clk (clk), .rst (rst), .above_rise (above_rise), .below_fall (below_fall),
    .pwm_level (pwm_level), .shutdown_req (shutdown_req)
  );

  function automatic bit next_level(bit lvl, bit a, bit b);
    if (a && !b) return 1'b1;
    if (b && !a) return 1'b0;
    return lvl;
  endfunction

  task automatic check(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Drive one sample at a negedge, advance the model, check at the next negedge.
  task automatic step(bit a, bit b, string tag);
    above_rise = a;
    below_fall = b;
    if (rst) begin
      m_level = 1'b0; m_shut = 1'b0; m_run = 0;
    end else begin
      m_level = next_level(m_level, a, b);
      if (!a && !b) begin
        if (!m_shut) begin
          m_run++;
          if (m_run >= HOLD) begin m_shut = 1'b1; m_run = 0; end
        end
      end else if (a && b) begin
        m_run = 0;
      end else begin
        m_run = 0; m_shut = 1'b0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "pwm_level", pwm_level, m_level);
    check(tag, "shutdown_req", shutdown_req, m_shut);
  endtask

  task automatic mid_run(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    // R8: window samples during reset must not count
    mid_run(HOLD + 5, "R8");
    step(1'b1, 1'b0, "R8");
    rst = 1'b0;
    step(1'b0, 1'b0, "R8");

    // R1: level follows edge zones
    step(1'b1, 1'b0, "R1");
    step(1'b0, 1'b1, "R1");
    step(1'b1, 1'b0, "R1");
    // R2: window holds the level
    mid_run(5, "R2");
    step(1'b0, 1'b1, "R1");
    mid_run(4, "R2");

    // R3: exactly HOLD window samples
    step(1'b1, 1'b0, "R3");
    mid_run(HOLD - 1, "R3");
    step(1'b0, 1'b0, "R3");
    // R4: stays while in window, then clears on exit
    mid_run(6, "R4");
    // R7: leave toward low while level held at 1
    step(1'b0, 1'b1, "R7");

    // R5: interrupted by an edge sample
    mid_run(HOLD - 1, "R5");
    step(1'b1, 1'b0, "R5");
    mid_run(HOLD - 1, "R5");
    step(1'b0, 1'b0, "R5");

    // R6: both flags set
    step(1'b1, 1'b1, "R6");
    mid_run(6, "R6");
    step(1'b1, 1'b1, "R6");
    step(1'b0, 1'b1, "R7");
    mid_run(HOLD - 1, "R6");
    step(1'b1, 1'b1, "R6");
    mid_run(HOLD - 1, "R6");
    step(1'b1, 1'b1, "R6");
    mid_run(HOLD, "R3");
    // R7: leave toward high from level 0
    step(1'b1, 1'b0, "R7");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int k = int'($urandom % 8);
      if (k < 2)       step(1'b1, 1'b0, "R1");
      else if (k < 4)  step(1'b0, 1'b1, "R1");
      else if (k == 4) step(1'b1, 1'b1, "R6");
      else             mid_run(int'($urandom % (HOLD + 6)), "R3");
    end

    // R8: reset mid-shutdown
    mid_run(HOLD, "R3");
    rst = 1'b1;
    step(1'b1, 1'b0, "R8");
    rst = 1'b0;
    step(1'b0, 1'b0, "R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule